// File: doc/BRIEF.md
# Control Endpoint Status Register

This block keeps the status flags of the control endpoint in a USB device function controller. The packet engine reports what happens on the bus through single-cycle strobes: a SETUP packet received, an OUT data packet received with its byte count and a short-packet qualifier, IN data delivered, the status phase starting, a protocol error, and the end of a setup stage. The CPU sets and clears flags through command strobes, and it writes two configuration bits. The first selects continuous gathering of OUT data. The second masks the data-end flag.

The six flags are read as one status vector. In continuous mode the block counts the OUT bytes it receives. It reports the OUT buffer as ready when a full set of bytes has arrived, when a short packet ends the data, or when the status phase begins while bytes are still waiting. A one-cycle interrupt request is raised whenever a flag changes in a way the CPU must act on. The packet engine gives at most one event per cycle.

Top module: `ctl_ep_status`

## Requirements
- R1: After reset, all six status bits read 0, the interrupt request is 0, the continuous-mode bit reads 0 and the data-end mask bit reads 1.
- R2: A SETUP strobe sets status bit 0 (OUT ready) and bit 2 (SETUP) in the next cycle and discards any gathered byte count. Bit 2 is never 1 while bit 0 is 0.
- R3: With continuous mode off, every OUT packet strobe sets bit 0 in the next cycle.
- R4: With continuous mode on, a normal OUT packet adds its length to a byte count. Bit 0 sets only when the count reaches SET_BYTES (default 128), and the count then restarts from zero.
- R5: With continuous mode on, an OUT packet marked short sets bit 0 and restarts the count.
- R6: A status-phase-start strobe sets bit 0 if gathered bytes are pending and leaves it unchanged if none are pending. In both cases the count restarts.
- R7: The CPU clear-OUT-ready strobe clears bits 0 and 2. A hardware event that sets either bit in the same cycle wins.
- R8: Bit 1 (IN ready) is set by the CPU. It is cleared by the IN-done strobe or the setup-end strobe, and the clear wins over a CPU set in the same cycle.
- R9: Bit 3 (data end) is set by the CPU. It is cleared by the status-phase-start strobe or the SETUP strobe, and the clear wins over a CPU set in the same cycle.
- R10: While the mask bit is 1, bit 3 reads 0. The flag underneath still holds its value and shows again when the mask is written to 0.
- R11: A protocol-error strobe sets bit 4 (forced stall). A setup-end strobe sets bit 5 and also clears bit 1. The CPU clears bit 4 or bit 5 with separate strobes, and a hardware set in the same cycle wins.
- R12: The interrupt request is high for one cycle, in the same cycle the flag change becomes visible, when any of these happens: bit 0 rises, bit 1 falls, the unmasked data-end flag falls, bit 4 rises, or bit 5 rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pe_setup | input | 1 | SETUP packet received |
| pe_out_pkt | input | 1 | OUT data packet received |
| pe_out_len | input | LEN_W | Byte count of the OUT packet |
| pe_out_short | input | 1 | OUT packet is shorter than the maximum packet size |
| pe_in_done | input | 1 | IN data delivered to the host |
| pe_status_start | input | 1 | Status phase started |
| pe_proto_err | input | 1 | Protocol error detected |
| pe_setup_end | input | 1 | Setup stage ended early |
| cpu_set_in_rdy | input | 1 | CPU sets IN ready |
| cpu_set_data_end | input | 1 | CPU sets data end |
| cpu_clr_out_rdy | input | 1 | CPU clears OUT ready and SETUP |
| cpu_clr_stall | input | 1 | CPU clears forced stall |
| cpu_clr_setup_end | input | 1 | CPU clears setup end |
| cpu_cfg_wr | input | 1 | Write the configuration bits |
| cpu_cfg_cont | input | 1 | New continuous-mode value |
| cpu_cfg_mask | input | 1 | New data-end mask value |
| ep_status | output | 6 | Status flags: bit0 OUT ready, bit1 IN ready, bit2 SETUP, bit3 data end, bit4 stall, bit5 setup end |
| ep_cfg_cont | output | 1 | Current continuous-mode bit |
| ep_cfg_mask | output | 1 | Current data-end mask bit |
| ep_irq | output | 1 | Endpoint interrupt pulse |

## Verification
The hardest case to reach from the ports is a status phase that begins while gathered bytes are pending. It needs continuous mode, a partial byte count below the set size, and no SETUP or short packet in between. The directed part of the bench builds this case both with pending bytes and without them. It also builds a count that lands exactly on 128 bytes over three packets. Random traffic then mixes mode writes, packet lengths from 1 to 64 and CPU strobes that collide with hardware events. A bench model predicts every flag and the interrupt request in every cycle.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
   localparam int unsigned FLAG_N   = 6;
   localparam int unsigned F_OUT    = 0;
   localparam int unsigned F_IN     = 1;
   localparam int unsigned F_SETUP  = 2;
   localparam int unsigned F_DEND   = 3;
   localparam int unsigned F_STALL  = 4;
   localparam int unsigned F_SEND   = 5;
   typedef logic [FLAG_N-1:0] flags_t;
endpackage

// File: rtl/ctl_ep_flag.sv
module ctl_ep_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic hw_clr,
   input  logic sw_set,
   input  logic sw_clr,
   output logic q,
   output logic d
);
   // hardware events outrank CPU commands
   always_comb begin
      if (hw_set)      d = 1'b1;
      else if (hw_clr) d = 1'b0;
      else if (sw_set) d = 1'b1;
      else if (sw_clr) d = 1'b0;
      else             d = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
   end
endmodule

// File: rtl/ctl_ep_gather.sv
module ctl_ep_gather #(
   parameter int unsigned SET_BYTES = 128,
   parameter int unsigned MAXP      = 64,
   parameter bit          CONT_EN   = 1'b1,
   localparam int unsigned LEN_W    = $clog2(MAXP + 1),
   localparam int unsigned ACC_W    = $clog2(SET_BYTES + MAXP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cont,
   input  logic             setup,
   input  logic             out_pkt,
   input  logic [LEN_W-1:0] out_len,
   input  logic             out_short,
   input  logic             status_start,
   output logic             set_rdy
);
   generate
      if (CONT_EN) begin : g_cont
         logic [ACC_W-1:0] acc_q, acc_d, sum;
         assign sum = acc_q + ACC_W'(out_len);

         always_comb begin
            acc_d   = acc_q;
            set_rdy = 1'b0;
            if (setup) begin
               acc_d = '0;
            end else if (out_pkt) begin
               if (!cont || out_short || sum >= ACC_W'(SET_BYTES)) begin
                  set_rdy = 1'b1;
                  acc_d   = '0;
               end else begin
                  acc_d = sum;
               end
            end else if (status_start) begin
               set_rdy = (acc_q != '0);
               acc_d   = '0;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) acc_q <= '0;
            else        acc_q <= acc_d;
         end
      end else begin : g_plain
         logic unused_in;
         assign unused_in = cont ^ setup ^ out_short ^ status_start ^ (^out_len) ^ clk ^ rst_n;
         assign set_rdy   = out_pkt;
      end
   endgenerate
endmodule

// File: rtl/ctl_ep_irq.sv
module ctl_ep_irq #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] q,
   input  logic [N-1:0] d,
   input  logic [N-1:0] rise_en,
   input  logic [N-1:0] fall_en,
   output logic         irq
);
   logic hit;
   assign hit = |((d & ~q & rise_en) | (~d & q & fall_en));

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= hit;
   end
endmodule

// File: rtl/ctl_ep_status.sv
module ctl_ep_status
   import ctl_ep_pkg::*;
#(
   parameter int unsigned SET_BYTES = 128,
   parameter int unsigned MAXP      = 64,
   parameter bit          CONT_EN   = 1'b1,
   localparam int unsigned LEN_W    = $clog2(MAXP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pe_setup,
   input  logic             pe_out_pkt,
   input  logic [LEN_W-1:0] pe_out_len,
   input  logic             pe_out_short,
   input  logic             pe_in_done,
   input  logic             pe_status_start,
   input  logic             pe_proto_err,
   input  logic             pe_setup_end,
   input  logic             cpu_set_in_rdy,
   input  logic             cpu_set_data_end,
   input  logic             cpu_clr_out_rdy,
   input  logic             cpu_clr_stall,
   input  logic             cpu_clr_setup_end,
   input  logic             cpu_cfg_wr,
   input  logic             cpu_cfg_cont,
   input  logic             cpu_cfg_mask,
   output logic [5:0]       ep_status,
   output logic             ep_cfg_cont,
   output logic             ep_cfg_mask,
   output logic             ep_irq
);
   if (SET_BYTES < MAXP) begin : g_bad_set
      $error("SET_BYTES must be at least MAXP");
   end
   if (MAXP < 8) begin : g_bad_maxp
      $error("MAXP must be at least 8");
   end

   logic   cont_q, mask_q, out_set;
   flags_t hw_set, hw_clr, sw_set, sw_clr, fq, fd, rise_en, fall_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cont_q <= 1'b0;
         mask_q <= 1'b1;
      end else if (cpu_cfg_wr) begin
         cont_q <= cpu_cfg_cont;
         mask_q <= cpu_cfg_mask;
      end
   end

   ctl_ep_gather #(.SET_BYTES(SET_BYTES), .MAXP(MAXP), .CONT_EN(CONT_EN)) u_gather (
      .clk(clk), .rst_n(rst_n), .cont(cont_q), .setup(pe_setup),
      .out_pkt(pe_out_pkt), .out_len(pe_out_len), .out_short(pe_out_short),
      .status_start(pe_status_start), .set_rdy(out_set)
   );

   always_comb begin
      hw_set = '0; hw_clr = '0; sw_set = '0; sw_clr = '0;
      hw_set[F_OUT]   = out_set | pe_setup;
      sw_clr[F_OUT]   = cpu_clr_out_rdy;
      hw_clr[F_IN]    = pe_in_done | pe_setup_end;
      sw_set[F_IN]    = cpu_set_in_rdy;
      hw_set[F_SETUP] = pe_setup;
      sw_clr[F_SETUP] = cpu_clr_out_rdy;
      hw_clr[F_DEND]  = pe_status_start | pe_setup;
      sw_set[F_DEND]  = cpu_set_data_end;
      hw_set[F_STALL] = pe_proto_err;
      sw_clr[F_STALL] = cpu_clr_stall;
      hw_set[F_SEND]  = pe_setup_end;
      sw_clr[F_SEND]  = cpu_clr_setup_end;
   end

   for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      ctl_ep_flag u_flag (
         .clk(clk), .rst_n(rst_n), .hw_set(hw_set[i]), .hw_clr(hw_clr[i]),
         .sw_set(sw_set[i]), .sw_clr(sw_clr[i]), .q(fq[i]), .d(fd[i])
      );
   end

   always_comb begin
      rise_en = '0; fall_en = '0;
      rise_en[F_OUT]   = 1'b1;
      rise_en[F_STALL] = 1'b1;
      rise_en[F_SEND]  = 1'b1;
      fall_en[F_IN]    = 1'b1;
      fall_en[F_DEND]  = ~mask_q;
   end

   ctl_ep_irq #(.N(FLAG_N)) u_irq (
      .clk(clk), .rst_n(rst_n), .q(fq), .d(fd),
      .rise_en(rise_en), .fall_en(fall_en), .irq(ep_irq)
   );

   always_comb begin
      ep_status         = fq;
      ep_status[F_DEND] = fq[F_DEND] & ~mask_q;
   end
   assign ep_cfg_cont = cont_q;
   assign ep_cfg_mask = mask_q;
endmodule

// File: rtl/ctl_ep_status_chk.sv
module ctl_ep_status_chk #(
   parameter int unsigned LEN_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pe_setup,
   input logic             pe_out_pkt,
   input logic [LEN_W-1:0] pe_out_len,
   input logic             pe_in_done,
   input logic             pe_proto_err,
   input logic             pe_setup_end,
   input logic [5:0]       ep_status,
   input logic             ep_cfg_cont,
   input logic             ep_cfg_mask,
   input logic             ep_irq
);
   // R2
   setup_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pe_setup |=> (ep_status[0] && ep_status[2]));
   // R2
   setup_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ep_status[2] |-> ep_status[0]);
   // R3
   noncont_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_out_pkt && !ep_cfg_cont && pe_out_len != '0) |=> ep_status[0]);
   // R8
   in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_in_done || pe_setup_end) |=> !ep_status[1]);
   // R10
   dend_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ep_cfg_mask |-> !ep_status[3]);
   // R11
   stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pe_proto_err |=> ep_status[4]);
   // R12
   stall_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ep_status[4]) |-> ep_irq);
   // R12
   send_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ep_status[5]) |-> ep_irq);
endmodule

bind ctl_ep_status ctl_ep_status_chk #(.LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pe_setup(pe_setup), .pe_out_pkt(pe_out_pkt),
   .pe_out_len(pe_out_len), .pe_in_done(pe_in_done), .pe_proto_err(pe_proto_err),
   .pe_setup_end(pe_setup_end), .ep_status(ep_status), .ep_cfg_cont(ep_cfg_cont),
   .ep_cfg_mask(ep_cfg_mask), .ep_irq(ep_irq)
);

// File: tb/test_ctl_ep_status.sv
module test_ctl_ep_status;
   localparam int SETB = 128;

   logic clk = 0, rst_n = 0;
   logic pe_setup = 0, pe_out_pkt = 0, pe_out_short = 0, pe_in_done = 0;
   logic pe_status_start = 0, pe_proto_err = 0, pe_setup_end = 0;
   logic [6:0] pe_out_len = 0;
   logic cpu_set_in_rdy = 0, cpu_set_data_end = 0, cpu_clr_out_rdy = 0;
   logic cpu_clr_stall = 0, cpu_clr_setup_end = 0;
   logic cpu_cfg_wr = 0, cpu_cfg_cont = 0, cpu_cfg_mask = 0;
   logic [5:0] ep_status;
   logic ep_cfg_cont, ep_cfg_mask, ep_irq;

   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   ctl_ep_status i_ctl_ep_status (
      .clk(clk), .rst_n(rst_n), .pe_setup(pe_setup), .pe_out_pkt(pe_out_pkt),
      .pe_out_len(pe_out_len), .pe_out_short(pe_out_short), .pe_in_done(pe_in_done),
      .pe_status_start(pe_status_start), .pe_proto_err(pe_proto_err),
      .pe_setup_end(pe_setup_end), .cpu_set_in_rdy(cpu_set_in_rdy),
      .cpu_set_data_end(cpu_set_data_end), .cpu_clr_out_rdy(cpu_clr_out_rdy),
      .cpu_clr_stall(cpu_clr_stall), .cpu_clr_setup_end(cpu_clr_setup_end),
      .cpu_cfg_wr(cpu_cfg_wr), .cpu_cfg_cont(cpu_cfg_cont), .cpu_cfg_mask(cpu_cfg_mask),
      .ep_status(ep_status), .ep_cfg_cont(ep_cfg_cont), .ep_cfg_mask(ep_cfg_mask),
      .ep_irq(ep_irq)
   );

   // behavioural model of the requirements
   logic m_out, m_in, m_stp, m_de, m_stl, m_se, m_cont, m_mask, m_irq;
   int   m_acc;

   function automatic logic fl_next(logic cur, logic hs, logic hc, logic ss, logic sc);
      if (hs) return 1'b1;
      if (hc) return 1'b0;
      if (ss) return 1'b1;
      if (sc) return 1'b0;
      return cur;
   endfunction

   always @(posedge clk) begin
      logic g, n_out, n_in, n_stp, n_de, n_stl, n_se;
      if (!rst_n) begin
         m_out = 0; m_in = 0; m_stp = 0; m_de = 0; m_stl = 0; m_se = 0;
         m_cont = 0; m_mask = 1; m_irq = 0; m_acc = 0;
      end else begin
         g = 0;
         if (pe_setup) m_acc = 0;
         else if (pe_out_pkt) begin
            if (!m_cont || pe_out_short || (m_acc + int'(pe_out_len)) >= SETB) begin
               g = 1; m_acc = 0;
            end else m_acc = m_acc + int'(pe_out_len);
         end else if (pe_status_start) begin
            g = (m_acc > 0); m_acc = 0;
         end
         n_out = fl_next(m_out, g | pe_setup, 0, 0, cpu_clr_out_rdy);
         n_stp = fl_next(m_stp, pe_setup, 0, 0, cpu_clr_out_rdy);
         n_in  = fl_next(m_in, 0, pe_in_done | pe_setup_end, cpu_set_in_rdy, 0);
         n_de  = fl_next(m_de, 0, pe_status_start | pe_setup, cpu_set_data_end, 0);
         n_stl = fl_next(m_stl, pe_proto_err, 0, 0, cpu_clr_stall);
         n_se  = fl_next(m_se, pe_setup_end, 0, 0, cpu_clr_setup_end);
         m_irq = (n_out & ~m_out) | (m_in & ~n_in) | (m_de & ~n_de & ~m_mask) |
                 (n_stl & ~m_stl) | (n_se & ~m_se);
         m_out = n_out; m_stp = n_stp; m_in = n_in; m_de = n_de; m_stl = n_stl; m_se = n_se;
         if (cpu_cfg_wr) begin m_cont = cpu_cfg_cont; m_mask = cpu_cfg_mask; end
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      chk("R4 out_rdy", ep_status[0], m_out);
      chk("R8 in_rdy", ep_status[1], m_in);
      chk("R2 setup", ep_status[2], m_stp);
      chk("R9 data_end", ep_status[3], m_de & ~m_mask);
      chk("R11 stall", ep_status[4], m_stl);
      chk("R11 setup_end", ep_status[5], m_se);
      chk("R12 irq", ep_irq, m_irq);
   endtask

   task automatic idle();
      pe_setup = 0; pe_out_pkt = 0; pe_out_short = 0; pe_in_done = 0;
      pe_status_start = 0; pe_proto_err = 0; pe_setup_end = 0; pe_out_len = 0;
      cpu_set_in_rdy = 0; cpu_set_data_end = 0; cpu_clr_out_rdy = 0;
      cpu_clr_stall = 0; cpu_clr_setup_end = 0; cpu_cfg_wr = 0;
   endtask

   task automatic tick();
      @(posedge clk); #2;
      compare_model();
      idle();
   endtask

   task automatic cfg(logic c, logic m);
      cpu_cfg_wr = 1; cpu_cfg_cont = c; cpu_cfg_mask = m; tick();
   endtask

   task automatic outp(int len, logic sh);
      pe_out_pkt = 1; pe_out_len = 7'(len); pe_out_short = sh; tick();
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #2; rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 status", ep_status, 0);
      chk("R1 irq", ep_irq, 0);
      chk("R1 mask", ep_cfg_mask, 1);
      chk("R1 cont", ep_cfg_cont, 0);
      // R10 masked data end reads zero
      cpu_set_data_end = 1; tick();
      chk("R10 masked", ep_status[3], 0);
      cfg(0, 0);
      chk("R10 unmasked", ep_status[3], 1);
      // R9 status start clears data end, R12 irq on unmasked fall
      pe_status_start = 1; tick();
      chk("R9 cleared", ep_status[3], 0);
      chk("R12 de_fall", ep_irq, 1);
      // R3 noncontinuous packet
      outp(8, 0);
      chk("R3 set", ep_status[0], 1);
      chk("R12 out_rise", ep_irq, 1);
      // R7 hardware set beats clear
      cpu_clr_out_rdy = 1; pe_out_pkt = 1; pe_out_len = 5; tick();
      chk("R7 hw_wins", ep_status[0], 1);
      chk("R12 no_rise", ep_irq, 0);
      cpu_clr_out_rdy = 1; tick();
      chk("R7 clear", ep_status[0], 0);
      // R4 continuous gather to exactly 128
      cfg(1, 0);
      outp(64, 0); chk("R4 partial", ep_status[0], 0);
      outp(63, 0); chk("R4 partial2", ep_status[0], 0);
      outp(1, 0);  chk("R4 full", ep_status[0], 1);
      chk("R12 full_irq", ep_irq, 1);
      cpu_clr_out_rdy = 1; tick();
      // R5 short packet
      outp(10, 1); chk("R5 short", ep_status[0], 1);
      cpu_clr_out_rdy = 1; tick();
      // R6 status start without and with pending bytes
      pe_status_start = 1; tick();
      chk("R6 none_pending", ep_status[0], 0);
      outp(20, 0); chk("R6 gathering", ep_status[0], 0);
      pe_status_start = 1; tick();
      chk("R6 pending", ep_status[0], 1);
      // R2 setup beats CPU clear
      cpu_clr_out_rdy = 1; pe_setup = 1; tick();
      chk("R2 out", ep_status[0], 1);
      chk("R2 setup", ep_status[2], 1);
      cpu_clr_out_rdy = 1; tick();
      chk("R7 setup_clr", ep_status[2], 0);
      // R8 in ready
      cpu_set_in_rdy = 1; pe_in_done = 1; tick();
      chk("R8 clr_wins", ep_status[1], 0);
      cpu_set_in_rdy = 1; tick();
      chk("R8 set", ep_status[1], 1);
      pe_setup_end = 1; tick();
      chk("R11 in_cleared", ep_status[1], 0);
      chk("R11 setup_end", ep_status[5], 1);
      chk("R12 se_irq", ep_irq, 1);
      pe_proto_err = 1; cpu_clr_stall = 1; tick();
      chk("R11 stall_wins", ep_status[4], 1);

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom_range(0, 15));
         case (r)
            0: pe_setup = 1;
            1, 2, 3, 4, 5: begin
               pe_out_pkt = 1;
               pe_out_len = 7'($urandom_range(64, 1));
               pe_out_short = ($urandom_range(0, 5) == 0);
            end
            6: pe_in_done = 1;
            7: pe_status_start = 1;
            8: pe_proto_err = 1;
            9: pe_setup_end = 1;
            default: ;
         endcase
         cpu_set_in_rdy    = ($urandom_range(0, 5) == 0);
         cpu_set_data_end  = ($urandom_range(0, 5) == 0);
         cpu_clr_out_rdy   = ($urandom_range(0, 4) == 0);
         cpu_clr_stall     = ($urandom_range(0, 5) == 0);
         cpu_clr_setup_end = ($urandom_range(0, 5) == 0);
         if ($urandom_range(0, 39) == 0) begin
            cpu_cfg_wr   = 1;
            cpu_cfg_cont = 1'($urandom_range(0, 1));
            cpu_cfg_mask = 1'($urandom_range(0, 1));
         end
         tick();
      end
      finish_run();
   end
endmodule